// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register file that sits between a host processor and a system controller. The host posts a command by first filling a 16-byte outbound payload buffer and then writing one 32-bit command word. That single write starts the transaction. It marks the mailbox busy, hands the decoded command fields to the controller and pulses a doorbell toward it. The controller reads the payload and does the work. It may then fill a 16-byte inbound reply buffer, and it finishes by pulsing a completion strobe that carries an error outcome.

The host either polls the status word until busy drops, or sets a per-command request bit inside the command word. When that bit is set, completion also produces a one-cycle edge interrupt that the host never has to clear. A command word written while the previous command is still outstanding is dropped. The controller can see this through a sticky overrun indication.

The host port is a plain register port: a write strobe, a byte address and write data, with read data returned combinationally for the presented address in word or byte form.

Top module: `mbox_ipc_regs`

## Requirements
- R1: A host write to offset 0x00 while not busy presents the word's fields to the controller (code = bits [7:0], interrupt request = bit 8, id = bits [15:12], size = bits [23:16]) and raises `c_doorbell` for exactly one cycle, in the cycle after the write.
- R2: In the cycle after an accepted command write, status bit 0 (busy) reads 1 and status bits [7:4] hold the command id.
- R3: Busy stays 1 until a `c_done` pulse. At that pulse busy clears, status bit 1 takes `c_err`, bits [23:16] take `c_err_code` and bits [15:8] take `c_init_id`. An accepted command clears bits [1] and [23:8].
- R4: When the completed command had bit 8 set, `host_irq` is 1 for exactly the one cycle after the `c_done` pulse. When bit 8 was clear, it stays 0.
- R5: A command write while busy is ignored: there is no doorbell, the presented fields and the status are unchanged, and `c_overrun` becomes 1 and stays 1 until reset.
- R6: Host word writes to offset 0x80 + 4k (k = 0..3) store word k of the outbound buffer, which the controller reads through `c_wb_idx`/`c_wb_word`.
- R7: Controller writes fill word k of the inbound buffer. A host word read at 0x90 + 4k returns that word. A byte read (`h_byte` = 1) at address A returns bits [8*A[1:0]+7 : 8*A[1:0]] of the addressed word, zero-extended.
- R8: Reads of the command register, the outbound buffer and any unmapped offset return 0. Host writes to the status word and the inbound buffer change nothing.
- R9: After reset, status reads 0, and `host_irq`, `c_doorbell` and `c_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_byte | input | 1 | 1 = byte read, 0 = word read |
| h_rdata | output | 32 | Host read data for `h_addr` |
| host_irq | output | 1 | One-cycle completion interrupt |
| c_doorbell | output | 1 | One-cycle new-command pulse |
| c_code | output | 8 | Current command code |
| c_id | output | 4 | Current command id |
| c_size | output | 8 | Current payload size in bytes |
| c_overrun | output | 1 | Sticky: command written while busy |
| c_wb_idx | input | 2 | Outbound buffer word select |
| c_wb_word | output | 32 | Outbound buffer word |
| c_rb_we | input | 1 | Inbound buffer word write |
| c_rb_idx | input | 2 | Inbound buffer word select |
| c_rb_wdata | input | 32 | Inbound buffer write data |
| c_done | input | 1 | Completion pulse |
| c_err | input | 1 | Completion error flag |
| c_err_code | input | 8 | Completion error code |
| c_init_id | input | 8 | Completion initiator id |

## Verification
The assertions watch the command handshake on every cycle. An accepted write must be followed by busy and a doorbell. Busy may drop only on a completion. The interrupt must be one cycle long and must follow busy falling. A write during busy must leave the command fields alone and latch the sticky overrun flag. Register layouts are shown only by the bench's scenarios: field positions in the command and status words, byte-lane selection in the inbound buffer, zero reads of write-only and unmapped offsets, and ignored writes to read-only locations. The bench also shows whether the interrupt is absent when the request bit is clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef struct packed {
      logic [7:0] size;
      logic [3:0] id;
      logic       irq_req;
      logic [7:0] code;
   } mbox_cmd_t;

   function automatic mbox_cmd_t unpack_cmd(input logic [31:0] w);
      mbox_cmd_t c;
      c.code    = w[7:0];
      c.irq_req = w[8];
      c.id      = w[15:12];
      c.size    = w[23:16];
      return c;
   endfunction

   function automatic logic [31:0] pack_status(input logic [7:0] ecode,
                                                input logic [7:0] iid,
                                                input logic [3:0] id,
                                                input logic       err,
                                                input logic       busy);
      return {8'h00, ecode, iid, id, 2'b00, err, busy};
   endfunction

endpackage

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
   parameter int NWORDS = 4,
   parameter int DW     = 32,
   localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] words [NWORDS];

   initial begin
      assert (NWORDS >= 1) else $error("mbox_wordbuf: NWORDS must be >= 1");
   end

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[k] <= '0;
         else if (we && (widx == IW'(k)))
            words[k] <= wdata;
      end
   end

   assign rdata = words[ridx];

endmodule

// File: rtl/mbox_cmd_ctl.sv
module mbox_cmd_ctl
   import mbox_pkg::*;
#(
   parameter bit IRQ_SUPPORT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_word,
   input  logic        done,
   input  logic        done_err,
   input  logic [7:0]  done_code,
   input  logic [7:0]  done_iid,
   output mbox_cmd_t   cmd_q,
   output logic        doorbell,
   output logic        busy,
   output logic [31:0] status_word,
   output logic        host_irq,
   output logic        overrun
);

   logic       err_q;
   logic [7:0] ecode_q;
   logic [7:0] iid_q;
   logic       accept;
   logic       finish;

   assign accept = cmd_wr && !busy;
   assign finish = done && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         doorbell <= 1'b0;
         busy     <= 1'b0;
         err_q    <= 1'b0;
         ecode_q  <= '0;
         iid_q    <= '0;
         overrun  <= 1'b0;
      end else begin
         doorbell <= accept;
         if (accept) begin
            cmd_q   <= unpack_cmd(cmd_word);
            busy    <= 1'b1;
            err_q   <= 1'b0;
            ecode_q <= '0;
            iid_q   <= '0;
         end else if (finish) begin
            busy    <= 1'b0;
            err_q   <= done_err;
            ecode_q <= done_code;
            iid_q   <= done_iid;
         end
         if (cmd_wr && busy)
            overrun <= 1'b1;
      end
   end

   assign status_word = pack_status(ecode_q, iid_q, cmd_q.id, err_q, busy);

   if (IRQ_SUPPORT) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= finish && cmd_q.irq_req;
      end
      assign host_irq = irq_q;

      // R4: interrupt lasts one cycle and follows busy falling
      p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
         host_irq |=> !host_irq);
      p_irq_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
         host_irq |-> (!busy && $past(busy)));
   end else begin : g_noirq
      assign host_irq = 1'b0;
   end

   // R1: accepted write produces a doorbell next cycle
   p_doorbell_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy) |=> doorbell);
   p_doorbell_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      doorbell |=> !doorbell);
   // R2: busy set after accepted write
   p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy) |=> busy);
   // R3: busy held until completion
   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R5: write while busy changes nothing and latches overrun
   p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy) |=> ($stable(cmd_q) && overrun && !doorbell));
   p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

endmodule

// File: rtl/mbox_ipc_regs.sv
module mbox_ipc_regs
   import mbox_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter int          BUF_BYTES   = 16,
   parameter logic [7:0]  CMD_OFF     = 8'h00,
   parameter logic [7:0]  STAT_OFF    = 8'h04,
   parameter logic [7:0]  WBUF_OFF    = 8'h80,
   parameter logic [7:0]  RBUF_OFF    = 8'h90,
   parameter bit          IRQ_SUPPORT = 1'b1,
   localparam int         NWORDS      = BUF_BYTES / 4,
   localparam int         IW          = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_byte,
   output logic [DATA_W-1:0] h_rdata,
   output logic              host_irq,
   output logic              c_doorbell,
   output logic [7:0]        c_code,
   output logic [3:0]        c_id,
   output logic [7:0]        c_size,
   output logic              c_overrun,
   input  logic [IW-1:0]     c_wb_idx,
   output logic [DATA_W-1:0] c_wb_word,
   input  logic              c_rb_we,
   input  logic [IW-1:0]     c_rb_idx,
   input  logic [DATA_W-1:0] c_rb_wdata,
   input  logic              c_done,
   input  logic              c_err,
   input  logic [7:0]        c_err_code,
   input  logic [7:0]        c_init_id
);

   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(BUF_BYTES);

   initial begin
      assert (DATA_W == 32)          else $error("mbox_ipc_regs: DATA_W must be 32");
      assert (BUF_BYTES % 4 == 0)    else $error("mbox_ipc_regs: BUF_BYTES must be a word multiple");
      assert (BUF_BYTES >= 4)        else $error("mbox_ipc_regs: BUF_BYTES too small");
      assert (ADDR_W == 8)           else $error("mbox_ipc_regs: ADDR_W must match offset width");
   end

   // ---------------- address decode ----------------
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] wb_off;
   logic [ADDR_W-1:0] rb_off;
   logic              hit_cmd, hit_stat, hit_wb, hit_rb;

   assign waddr    = {h_addr[ADDR_W-1:2], 2'b00};
   assign wb_off   = h_addr - WBUF_OFF;
   assign rb_off   = h_addr - RBUF_OFF;
   assign hit_cmd  = (waddr == CMD_OFF);
   assign hit_stat = (waddr == STAT_OFF);
   assign hit_wb   = (wb_off < SPAN);
   assign hit_rb   = (rb_off < SPAN);

   // ---------------- command / status ----------------
   mbox_cmd_t   cmd_q;
   logic        busy;
   logic [31:0] status_word;

   mbox_cmd_ctl #(.IRQ_SUPPORT(IRQ_SUPPORT)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (h_wr && hit_cmd),
      .cmd_word    (h_wdata),
      .done        (c_done),
      .done_err    (c_err),
      .done_code   (c_err_code),
      .done_iid    (c_init_id),
      .cmd_q       (cmd_q),
      .doorbell    (c_doorbell),
      .busy        (busy),
      .status_word (status_word),
      .host_irq    (host_irq),
      .overrun     (c_overrun)
   );

   assign c_code = cmd_q.code;
   assign c_id   = cmd_q.id;
   assign c_size = cmd_q.size;

   // ---------------- outbound buffer (host writes) ----------------
   mbox_wordbuf #(.NWORDS(NWORDS), .DW(DATA_W)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (h_wr && hit_wb),
      .widx  (wb_off[IW+1:2]),
      .wdata (h_wdata),
      .ridx  (c_wb_idx),
      .rdata (c_wb_word)
   );

   // ---------------- inbound buffer (controller writes) ----------------
   logic [DATA_W-1:0] rb_word;

   mbox_wordbuf #(.NWORDS(NWORDS), .DW(DATA_W)) u_rbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (c_rb_we),
      .widx  (c_rb_idx),
      .wdata (c_rb_wdata),
      .ridx  (rb_off[IW+1:2]),
      .rdata (rb_word)
   );

   // ---------------- host read mux ----------------
   logic [DATA_W-1:0] word_sel;
   logic [7:0]        byte_sel;

   always_comb begin
      if (hit_stat)    word_sel = status_word;
      else if (hit_rb) word_sel = rb_word;
      else             word_sel = '0;
   end

   always_comb begin
      case (h_addr[1:0])
         2'd0:    byte_sel = word_sel[7:0];
         2'd1:    byte_sel = word_sel[15:8];
         2'd2:    byte_sel = word_sel[23:16];
         default: byte_sel = word_sel[31:24];
      endcase
   end

   assign h_rdata = h_byte ? {{(DATA_W-8){1'b0}}, byte_sel} : word_sel;

   // R8: command register and outbound buffer never read back
   p_wo_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cmd || hit_wb) |-> (h_rdata == '0));

endmodule

// File: tb/sim_mbox_ipc_regs.sv
module sim_mbox_ipc_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_wr = 1'b0;
   logic [7:0]  h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic        h_byte = 1'b0;
   logic [31:0] h_rdata;
   logic        host_irq, c_doorbell, c_overrun;
   logic [7:0]  c_code, c_size;
   logic [3:0]  c_id;
   logic [1:0]  c_wb_idx = '0;
   logic [31:0] c_wb_word;
   logic        c_rb_we = 1'b0;
   logic [1:0]  c_rb_idx = '0;
   logic [31:0] c_rb_wdata = '0;
   logic        c_done = 1'b0, c_err = 1'b0;
   logic [7:0]  c_err_code = '0, c_init_id = '0;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   mbox_ipc_regs u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      h_wr = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic host_rd(input logic [7:0] a, input logic bytemode, output logic [31:0] d);
      h_addr = a; h_byte = bytemode;
      #1 d = h_rdata;
      h_byte = 1'b0;
   endtask

   task automatic ctrl_done(input logic e, input logic [7:0] code, input logic [7:0] iid);
      @(negedge clk);
      c_done = 1'b1; c_err = e; c_err_code = code; c_init_id = iid;
      @(negedge clk);
      c_done = 1'b0; c_err = 1'b0; c_err_code = '0; c_init_id = '0;
   endtask

   task automatic ctrl_rb_wr(input logic [1:0] k, input logic [31:0] d);
      @(negedge clk);
      c_rb_we = 1'b1; c_rb_idx = k; c_rb_wdata = d;
      @(negedge clk);
      c_rb_we = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      host_rd(8'h04, 1'b0, d);
      chk("R9 status", d, 32'h0);
      chk("R9 irq", {31'b0, host_irq}, 32'h0);
      chk("R9 doorbell", {31'b0, c_doorbell}, 32'h0);
      chk("R9 overrun", {31'b0, c_overrun}, 32'h0);
   endtask

   task automatic t_wbuf();
      logic [31:0] d;
      for (int k = 0; k < 4; k++) host_wr(8'h80 + 8'(4*k), 32'hC0DE_0000 + 32'(k));
      for (int k = 0; k < 4; k++) begin
         c_wb_idx = 2'(k);
         #1 chk("R6 outbound word", c_wb_word, 32'hC0DE_0000 + 32'(k));
      end
      host_rd(8'h84, 1'b0, d);
      chk("R8 outbound reads zero", d, 32'h0);
   endtask

   task automatic t_cmd_irq();
      logic [31:0] d;
      host_wr(8'h00, 32'hFF08_31A5);
      chk("R1 doorbell", {31'b0, c_doorbell}, 32'h1);
      chk("R1 code", {24'b0, c_code}, 32'hA5);
      chk("R1 id", {28'b0, c_id}, 32'h3);
      chk("R1 size", {24'b0, c_size}, 32'h08);
      host_rd(8'h04, 1'b0, d);
      chk("R2 status busy+id", d, 32'h0000_0031);
      host_rd(8'h00, 1'b0, d);
      chk("R8 command reads zero", d, 32'h0);
      @(negedge clk);
      chk("R1 doorbell one cycle", {31'b0, c_doorbell}, 32'h0);
      repeat (3) @(negedge clk);
      host_rd(8'h04, 1'b0, d);
      chk("R3 busy held", d, 32'h0000_0031);
      ctrl_done(1'b1, 8'h5A, 8'h11);
      chk("R4 irq on completion", {31'b0, host_irq}, 32'h1);
      host_rd(8'h04, 1'b0, d);
      chk("R3 status after done", d, 32'h005A_1132);
      @(negedge clk);
      chk("R4 irq one cycle", {31'b0, host_irq}, 32'h0);
   endtask

   task automatic t_overrun();
      logic [31:0] d;
      host_wr(8'h00, 32'h0004_0207);
      host_rd(8'h04, 1'b0, d);
      chk("R3 accept clears error", d, 32'h0000_0001);
      @(negedge clk);
      host_wr(8'h00, 32'h000C_F0FF);
      chk("R5 no doorbell", {31'b0, c_doorbell}, 32'h0);
      chk("R5 id kept", {28'b0, c_id}, 32'h0);
      chk("R5 code kept", {24'b0, c_code}, 32'h07);
      chk("R5 overrun set", {31'b0, c_overrun}, 32'h1);
      host_rd(8'h04, 1'b0, d);
      chk("R5 status kept", d, 32'h0000_0001);
      ctrl_done(1'b0, 8'h00, 8'h22);
      chk("R4 no irq without request", {31'b0, host_irq}, 32'h0);
      host_rd(8'h04, 1'b0, d);
      chk("R3 status ok completion", d, 32'h0000_2200);
      @(negedge clk);
      chk("R4 no irq later", {31'b0, host_irq}, 32'h0);
      chk("R5 overrun sticky", {31'b0, c_overrun}, 32'h1);
   endtask

   task automatic t_rbuf();
      logic [31:0] d;
      ctrl_rb_wr(2'd0, 32'h1122_3344);
      ctrl_rb_wr(2'd1, 32'hAABB_CCDD);
      ctrl_rb_wr(2'd3, 32'h5566_7788);
      host_rd(8'h94, 1'b0, d);
      chk("R7 word read", d, 32'hAABB_CCDD);
      host_rd(8'h95, 1'b1, d);
      chk("R7 byte lane 1", d, 32'h0000_00CC);
      host_rd(8'h90, 1'b1, d);
      chk("R7 byte lane 0", d, 32'h0000_0044);
      host_rd(8'h9F, 1'b1, d);
      chk("R7 byte lane 3", d, 32'h0000_0055);
      host_rd(8'h98, 1'b0, d);
      chk("R7 unwritten word", d, 32'h0);
   endtask

   task automatic t_readonly();
      logic [31:0] d;
      host_wr(8'h04, 32'hFFFF_FFFF);
      host_rd(8'h04, 1'b0, d);
      chk("R8 status write ignored", d, 32'h0000_2200);
      chk("R8 no doorbell on status write", {31'b0, c_doorbell}, 32'h0);
      host_wr(8'h94, 32'h0BAD_0BAD);
      host_rd(8'h94, 1'b0, d);
      chk("R8 inbound write ignored", d, 32'hAABB_CCDD);
      host_rd(8'h40, 1'b0, d);
      chk("R8 unmapped reads zero", d, 32'h0);
      host_rd(8'hA0, 1'b0, d);
      chk("R8 past inbound reads zero", d, 32'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wbuf();
      t_cmd_irq();
      t_overrun();
      t_rbuf();
      t_readonly();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule